// File: doc/BRIEF.md
# Page-Mode DRAM Sequencer

This block sits between a simple synchronous request port and an asynchronous DRAM with multiplexed row and column address lines. It accepts one request at a time. A request carries a flat word address, a direction and a beat count. The block splits the address into a row half and a column half, opens the row by lowering the row strobe, and then issues one column strobe pulse for each beat while the row stays open. Beats in a burst use consecutive columns of that row and wrap within the row.

Every analogue timing interval is a parameter counted in clock cycles. The defaults suit a 10 ns clock:
- 4 cycles from row strobe to the first column strobe.
- 2 cycles of column strobe low.
- 2 cycles of column strobe high between beats.
- 6 cycles of row precharge.

This gives a 6-4-4-4 beat pattern. Read data is captured on the last clock of each column-strobe-low interval and handed to the host with a one-cycle valid pulse. Write data is requested from the host one beat at a time and held on the DRAM data-in pins for the whole column-strobe-low interval.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, both strobes and the write enable are high (inactive), `req_ready` is 1 and `rd_valid` is 0.
- R2: The row is `req_addr[15:8]`. It is on `dram_addr` when the row strobe falls and stays there until the column strobe falls. The column is `req_addr[7:0]`. It is on `dram_addr` at each column strobe fall and stays stable while the column strobe is low.
- R3: A burst gives exactly one row strobe fall and one column strobe pulse per beat. The column strobe is low only while the row strobe is low. Beat k uses column (start + k) mod 256 in the same row.
- R4: The column strobe falls `RCD_CYC` cycles after the row strobe falls and stays low `CAS_CYC` cycles. Later beats start `CAS_CYC+GAP_CYC` cycles apart. With the defaults, read beat k shows `rd_valid` 6+4k cycles after the accepting edge.
- R5: On a read, the DRAM data present at the last clock of each column-strobe-low interval appears on `rd_data`. This happens in the next cycle, with `rd_valid` high for that single cycle. Writes produce no `rd_valid`.
- R6: During a write, `dram_we_n` is low whenever the row strobe is low, so it is already low before any column strobe falls. `wr_ack` pulses once per beat, in the cycle whose clock edge loads `wr_data` onto `dram_din`. `dram_din` holds still while the column strobe is low.
- R7: After the last beat the row strobe stays high for at least `PRE_CYC` cycles. `req_ready` is high only once that precharge is over; with the defaults that is 12+4(n-1) cycles after accept for an n-beat burst.
- R8: A request is taken only at a clock edge where `req_valid` and `req_ready` are both 1. It performs exactly `req_len+1` beats and leaves other columns untouched.
- R9: Data written by bursts in different rows and columns reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and precharged, request can be taken |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | 16 | Word address, row in the upper half, column in the lower half |
| req_len | input | 2 | Beat count minus one |
| wr_data | input | 4 | Write data for the current beat |
| wr_ack | output | 1 | Current write beat taken at this clock edge |
| rd_data | output | 4 | Read beat data |
| rd_valid | output | 1 | One-cycle pulse marking a read beat |
| dram_addr | output | 8 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_din | output | 4 | Data to the DRAM |
| dram_dout | input | 4 | Data from the DRAM |

## Verification
The bench drives a behavioural DRAM that returns inverted data unless both the row-access and the column-access delays have elapsed. A controller that samples a cycle too early therefore shows corrupted read data instead of a timing slip that goes unnoticed. The same model records the row and column latched at each strobe edge and flags row reopenings closer than 11 cycles, column pulses closer than 4, and write enable or data moving under a low column strobe. Because of this, swapped address halves, a missing precharge or a shortened gap each show up as a violation or a wrong captured address.

A burst that starts at column 0xFE checks the wrap inside the row. A design that carries into the row would write the neighbouring row and fail the readback. A two-beat write over a prefilled four-word region shows whether the beat count is off by one, because the third word would be overwritten.

// File: rtl/fpm_pkg.sv
// Shared types and helpers for the page-mode DRAM sequencer.
// Assumes nothing beyond IEEE 1800-2017 elaboration-time functions.
package fpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // row closed, precharge complete
        ST_ROW,    // row strobe low, row address out, waiting for first column
        ST_CAS,    // column strobe low
        ST_GAP,    // column strobe high between beats, row still open
        ST_PRE     // row strobe high, precharge countdown
    } fpm_state_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/fpm_sequencer.sv
// Strobe state machine. Counts each timing phase in clock cycles, tracks
// the beats left in the burst and decodes the three DRAM strobes.
// Assumes every timing parameter is at least 1.
module fpm_sequencer
    import fpm_pkg::*;
#(
    parameter int LEN_W   = 2,
    parameter int RCD_CYC = 4,
    parameter int CAS_CYC = 2,
    parameter int GAP_CYC = 2,
    parameter int PRE_CYC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [LEN_W-1:0] req_len,
    output logic             req_ready,
    output logic             accept,
    output logic             row_phase,
    output logic             col_step,
    output logic             wr_take,
    output logic             rd_take,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n
);

    localparam int MAXC  = max4(RCD_CYC, CAS_CYC, GAP_CYC, PRE_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);

    fpm_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [LEN_W-1:0] left;
    logic             is_wr;
    logic             phase_end;

    assign phase_end = (cnt == '0);
    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign row_phase = (state == ST_ROW);
    assign col_step  = (state == ST_CAS) && phase_end && (left != '0);
    assign wr_take   = is_wr && phase_end && ((state == ST_ROW) || (state == ST_GAP));
    assign rd_take   = !is_wr && phase_end && (state == ST_CAS);

    // Strobe decode: row open in ROW, CAS and GAP; column only in CAS.
    always_comb begin
        ras_n = !((state == ST_ROW) || (state == ST_CAS) || (state == ST_GAP));
        cas_n = (state != ST_CAS);
        we_n  = !(is_wr && !ras_n);
    end

    // Phase sequencing with per-phase cycle countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            left  <= '0;
            is_wr <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    state <= ST_ROW;
                    cnt   <= CNT_W'(RCD_CYC - 1);
                    left  <= req_len;
                    is_wr <= req_write;
                end
                ST_ROW: if (phase_end) begin
                    state <= ST_CAS;
                    cnt   <= CNT_W'(CAS_CYC - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                ST_CAS: if (phase_end) begin
                    if (left == '0) begin
                        state <= ST_PRE;
                        cnt   <= CNT_W'(PRE_CYC - 1);
                    end else begin
                        state <= ST_GAP;
                        cnt   <= CNT_W'(GAP_CYC - 1);
                        left  <= left - 1'b1;
                    end
                end else begin
                    cnt <= cnt - 1'b1;
                end
                ST_GAP: if (phase_end) begin
                    state <= ST_CAS;
                    cnt   <= CNT_W'(CAS_CYC - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                ST_PRE: if (phase_end) begin
                    state <= ST_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Checker state: cycles the row strobe has been high, saturating.
    logic [CNT_W:0] hi_run;
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_run <= (CNT_W+1)'(PRE_CYC);
        else if (!ras_n)
            hi_run <= '0;
        else if (hi_run < (CNT_W+1)'(PRE_CYC))
            hi_run <= hi_run + 1'b1;
    end

    assert_cas_inside_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    assert_ready_row_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ras_n);

    assert_precharge_dwell_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_run >= (CNT_W+1)'(PRE_CYC)));

    assert_we_before_cas_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !we_n) |-> !$past(we_n));

endmodule

// File: rtl/fpm_addr_path.sv
// Address path: holds the row and the running column of the open burst
// and multiplexes them onto the shared DRAM address pins.
// Assumes the column advances only between column strobe pulses.
module fpm_addr_path #(
    parameter int ROW_W  = 8,
    localparam int ADDR_W = 2 * ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              col_step,
    input  logic              row_phase,
    input  logic              cas_n,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [ROW_W-1:0]  dram_addr
);

    logic [ROW_W-1:0] row_q;
    logic [ROW_W-1:0] col_q;

    // Capture address halves on accept; step column within the row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (load) begin
            row_q <= req_addr[ADDR_W-1:ROW_W];
            col_q <= req_addr[ROW_W-1:0];
        end else if (col_step) begin
            col_q <= col_q + 1'b1;
        end
    end

    // Row half while opening the row, column half otherwise.
    assign dram_addr = row_phase ? row_q : col_q;

    assert_addr_hold_under_cas_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && $past(!cas_n)) |-> $stable(dram_addr));

endmodule

// File: rtl/fpm_data_path.sv
// Data path: registers write beats onto the DRAM data-in pins and
// captures read beats with a one-cycle valid flag.
// Assumes wr_take and rd_take come from the strobe sequencer.
module fpm_data_path #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_take,
    input  logic              rd_take,
    input  logic              cas_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] dram_dout,
    output logic [DATA_W-1:0] dram_din,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    // Write beat register, loaded as the column strobe falls.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dram_din <= '0;
        else if (wr_take)
            dram_din <= wr_data;
    end

    // Read capture at the end of the column-strobe-low interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_take;
            if (rd_take)
                rd_data <= dram_dout;
        end
    end

    assert_din_hold_under_cas_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && $past(!cas_n)) |-> $stable(dram_din));

    assert_rd_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/fpm_dram_ctrl.sv
// Page-mode DRAM controller top. Takes one burst request at a time, opens
// the row once and issues one column pulse per beat within that row.
// Assumes an asynchronous DRAM whose timing is met by the cycle-count
// parameters at the chosen clock period.
module fpm_dram_ctrl #(
    parameter int ROW_W   = 8,
    parameter int DATA_W  = 4,
    parameter int LEN_W   = 2,
    parameter int RCD_CYC = 4,
    parameter int CAS_CYC = 2,
    parameter int GAP_CYC = 2,
    parameter int PRE_CYC = 6,
    localparam int ADDR_W = 2 * ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ROW_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [DATA_W-1:0] dram_din,
    input  logic [DATA_W-1:0] dram_dout
);

    logic accept;
    logic row_phase;
    logic col_step;
    logic rd_take;

    fpm_sequencer #(
        .LEN_W  (LEN_W),
        .RCD_CYC(RCD_CYC),
        .CAS_CYC(CAS_CYC),
        .GAP_CYC(GAP_CYC),
        .PRE_CYC(PRE_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_len  (req_len),
        .req_ready(req_ready),
        .accept   (accept),
        .row_phase(row_phase),
        .col_step (col_step),
        .wr_take  (wr_ack),
        .rd_take  (rd_take),
        .ras_n    (dram_ras_n),
        .cas_n    (dram_cas_n),
        .we_n     (dram_we_n)
    );

    fpm_addr_path #(
        .ROW_W(ROW_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .col_step (col_step),
        .row_phase(row_phase),
        .cas_n    (dram_cas_n),
        .req_addr (req_addr),
        .dram_addr(dram_addr)
    );

    fpm_data_path #(
        .DATA_W(DATA_W)
    ) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_take  (wr_ack),
        .rd_take  (rd_take),
        .cas_n    (dram_cas_n),
        .wr_data  (wr_data),
        .dram_dout(dram_dout),
        .dram_din (dram_din),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: tb/tb_fpm_dram_ctrl.sv
// Directed bench with a behavioural DRAM that enforces access and
// spacing times and returns corrupted data when sampled too early.
module tb_fpm_dram_ctrl;

    localparam int ROW_W = 8, DATA_W = 4, LEN_W = 2;
    localparam int RC_MIN = 11, PC_MIN = 4, RAC_CYC = 6, CAC_CYC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic req_ready, wr_ack, rd_valid;
    logic [DATA_W-1:0] rd_data, dram_din, dram_dout;
    logic [ROW_W-1:0] dram_addr;
    logic dram_ras_n, dram_cas_n, dram_we_n;

    fpm_dram_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
        .wr_data(wr_data), .wr_ack(wr_ack), .rd_data(rd_data), .rd_valid(rd_valid),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_din(dram_din), .dram_dout(dram_dout)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural DRAM ----------------
    logic [DATA_W-1:0] mem [int];
    logic [DATA_W-1:0] refm [int];
    logic [DATA_W-1:0] dout_q = '0;
    assign dram_dout = dout_q;
    logic prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1, we_at_fall = 1'b1;
    logic [ROW_W-1:0] m_row = '0, m_col = '0;
    logic [DATA_W-1:0] din_at_fall = '0;
    int ras_fall_at = -1000, cas_fall_at = -1000;
    int ras_low_n = 0, cas_low_n = 0, n_ras = 0, n_cas = 0, viol = 0;

    function automatic logic [DATA_W-1:0] mem_rd(input int key);
        if (mem.exists(key)) return mem[key];
        return '0;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras && !dram_ras_n) begin
                if (cyc - ras_fall_at < RC_MIN) begin
                    viol++; $display("model: row cycle too short at %0d", cyc);
                end
                ras_fall_at = cyc; m_row = dram_addr; n_ras++; ras_low_n = 0;
            end
            if (!dram_ras_n) ras_low_n++;
            if (prev_cas && !dram_cas_n) begin
                if (dram_ras_n) begin viol++; $display("model: column without row"); end
                if (cyc - cas_fall_at < PC_MIN) begin
                    viol++; $display("model: page cycle too short at %0d", cyc);
                end
                if (!dram_we_n && prev_we) begin viol++; $display("model: late write enable"); end
                cas_fall_at = cyc; m_col = dram_addr; n_cas++; cas_low_n = 0;
                we_at_fall = dram_we_n; din_at_fall = dram_din;
                if (!dram_we_n) mem[int'({m_row, m_col})] = dram_din;
            end
            if (!dram_cas_n) begin
                cas_low_n++;
                if (dram_we_n != we_at_fall) begin viol++; $display("model: write enable moved"); end
                if (!we_at_fall && dram_din != din_at_fall) begin
                    viol++; $display("model: write data moved");
                end
                if (ras_low_n >= RAC_CYC && cas_low_n >= CAC_CYC)
                    dout_q = mem_rd(int'({m_row, m_col}));
                else
                    dout_q = ~mem_rd(int'({m_row, m_col}));
            end
            prev_ras = dram_ras_n; prev_cas = dram_cas_n; prev_we = dram_we_n;
        end
    end

    // ---------------- request driver ----------------
    logic [DATA_W-1:0] wbuf [4];
    logic [DATA_W-1:0] got [4];
    int got_at [4];
    int ngot, nack, fin_k, ras_d, cas_d;
    logic [ROW_W-1:0] row_seen;

    task automatic run_req(input logic wr, input logic [15:0] a, input int nb);
        int k, widx, ras0, cas0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        req_len = LEN_W'(nb - 1); wr_data = wbuf[0];
        ras0 = n_ras; cas0 = n_cas;
        k = 0; widx = 0; ngot = 0; nack = 0;
        do begin
            @(negedge clk);
            k++;
            req_valid = 1'b0;
            if (k == 2) row_seen = m_row;
            wr_data = wbuf[widx < 4 ? widx : 3];
            if (wr_ack) begin
                nack++;
                if (wr) refm[int'({a[15:8], 8'(a[7:0] + 8'(widx))})] = wbuf[widx < 4 ? widx : 3];
                widx++;
            end
            if (rd_valid && ngot < 4) begin
                got[ngot] = rd_data; got_at[ngot] = k; ngot++;
            end
        end while (!req_ready && k < 300);
        fin_k = k; ras_d = n_ras - ras0; cas_d = n_cas - cas0;
    endtask

    function automatic int ref_rd(input logic [15:0] a);
        if (refm.exists(int'(a))) return int'(refm[int'(a)]);
        return 0;
    endfunction

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes idle", {dram_ras_n, dram_cas_n, dram_we_n}, 7);
        chk(req_ready === 1'b1, "R1 ready after reset", req_ready, 1);
        chk(rd_valid === 1'b0, "R1 no read valid", rd_valid, 0);
    endtask

    task automatic t_single();
        wbuf[0] = 4'hA;
        run_req(1'b1, 16'h1234, 1);
        chk(row_seen == 8'h12, "R2 row half", row_seen, 8'h12);
        chk(m_col == 8'h34, "R2 column half", m_col, 8'h34);
        chk(nack == 1, "R6 one write ack", nack, 1);
        chk(ngot == 0, "R5 no valid on write", ngot, 0);
        run_req(1'b0, 16'h1234, 1);
        chk(ras_d == 1 && cas_d == 1, "R3 single strobes", ras_d * 10 + cas_d, 11);
        chk(ngot == 1 && got_at[0] == 7, "R4 first beat time", got_at[0], 7);
        chk(got[0] == 4'hA, "R5 read data", got[0], 4'hA);
        chk(fin_k == 13, "R7 ready after precharge", fin_k, 13);
    endtask

    task automatic t_burst_wrap();
        wbuf = '{4'h1, 4'h7, 4'hC, 4'h5};
        run_req(1'b1, 16'h56FE, 4);
        chk(nack == 4, "R6 ack per beat", nack, 4);
        chk(ras_d == 1 && cas_d == 4, "R3 one row many columns", ras_d * 10 + cas_d, 14);
        chk(m_col == 8'h01, "R3 column wraps in row", m_col, 1);
        run_req(1'b0, 16'h56FE, 4);
        chk(ngot == 4, "R8 four beats", ngot, 4);
        for (int i = 0; i < 4; i++) begin
            chk(got_at[i] == 7 + 4 * i, "R4 beat spacing", got_at[i], 7 + 4 * i);
            chk(int'(got[i]) == ref_rd({8'h56, 8'(8'hFE + i)}), "R9 burst readback",
                got[i], ref_rd({8'h56, 8'(8'hFE + i)}));
        end
        chk(fin_k == 25, "R7 four-beat ready", fin_k, 25);
        chk(int'(mem_rd(int'(16'h5700))) == 0, "R3 next row untouched", mem_rd(int'(16'h5700)), 0);
    endtask

    task automatic t_len();
        wbuf = '{4'h3, 4'h4, 4'h6, 4'h8};
        run_req(1'b1, 16'h7710, 4);
        wbuf = '{4'hE, 4'hD, 4'h0, 4'h0};
        run_req(1'b1, 16'h7710, 2);
        chk(nack == 2 && cas_d == 2, "R8 two-beat write", cas_d, 2);
        run_req(1'b0, 16'h7710, 4);
        chk(got[0] == 4'hE && got[1] == 4'hD, "R8 new words", {got[0], got[1]}, 8'hED);
        chk(got[2] == 4'h6 && got[3] == 4'h8, "R8 neighbours kept", {got[2], got[3]}, 8'h68);
    endtask

    task automatic t_rows();
        wbuf[0] = 4'h9; run_req(1'b1, 16'h0005, 1);
        wbuf[0] = 4'h2; run_req(1'b1, 16'hFF05, 1);
        wbuf[0] = 4'hB; run_req(1'b1, 16'h0500, 1);
        run_req(1'b0, 16'h0005, 1);
        chk(got[0] == 4'h9, "R9 row 00", got[0], 9);
        run_req(1'b0, 16'hFF05, 1);
        chk(got[0] == 4'h2, "R9 row FF", got[0], 2);
        run_req(1'b0, 16'h0500, 1);
        chk(got[0] == 4'hB && row_seen == 8'h05, "R2 swapped halves distinct", got[0], 4'hB);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_burst_wrap();
        t_len();
        t_rows();
        chk(viol == 0, "R4 R7 DRAM timing violations", viol, 0);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog R8 actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule